// File: doc/BRIEF.md
# Bridge Excitation Clock Generator

This block drives a sensor bridge with switched-DC excitation. It uses a two-bit frequency code to divide the master clock down to a square wave. Code 0 gives steady DC excitation. The block produces two complementary drive levels, one on each side of the bridge. It also produces a demodulation phase flag that marks which polarity is currently applied.

A mode input hands control of the phase to an external pin. In that mode the first drive pin is released and acts as an input. Its synchronized level then sets the demodulation phase and the level on the second drive pin.

A small demodulator inside the block undoes the polarity reversal on the sample stream. It passes a sample unchanged in phase 0. In phase 1 it negates the sample in two's complement, saturating so the result always fits. The block emits a one-cycle strobe when the phase flips or when the excitation settings change, so that downstream filtering can restart.

Top module: `exc_bridge_drive`

## Requirements
- R1: With `ext_mode`=0 and `fsel`=0, the outputs hold DC levels: `bx1_out`=0, `bx2_out`=1, `demod_phase`=0, `bx1_oe`=1.
- R2: With `ext_mode`=0, `fsel` selects the full excitation period. Code 3 gives 2^BASE_LG master clocks, code 1 gives 2^(BASE_LG+1), and code 2 gives 2^(BASE_LG+2). Each period is two equal halves, with `bx1_out` low in the first half and high in the second.
- R3: With `ext_mode`=0, `bx2_out` is always the complement of `bx1_out`, and `demod_phase` equals `bx1_out`.
- R4: With `ext_mode`=1, `bx1_oe`=0. `demod_phase` follows `bx1_in` after SYNC_STAGES+1 clock edges, and `bx2_out` is its complement.
- R5: A change of `fsel` or `ext_mode` at clock edge e restarts the divider from zero. `phase_strobe` is high after edge e. `bx1_out` is then low until edge e+H, where H is the half-period, and rises at edge e+H+1.
- R6: `phase_strobe` is high in every cycle in which `demod_phase` differs from its value in the previous cycle.
- R7: When `sample_valid_in` is high at an edge, then after that edge `sample_valid_out` is high. `sample_out` equals `sample_in` if `demod_phase` was 0 at that edge, and equals -`sample_in` (two's complement, DATA_W bits) if it was 1. When `sample_valid_in` is low, `sample_valid_out` goes low.
- R8: In phase 1, the most negative input (-2^(DATA_W-1)) produces the most positive value (2^(DATA_W-1)-1).
- R9: While `rst` is high, the outputs are `bx1_out`=0, `bx2_out`=1, `bx1_oe`=1, `demod_phase`=0, `phase_strobe`=0 and `sample_valid_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 = phase taken from `bx1_in`, 0 = internal divider |
| fsel | input | 2 | Excitation frequency code (0 = DC) |
| bx1_in | input | 1 | First drive pin level when it acts as an input |
| sample_in | input | DATA_W | Signed sample to demodulate |
| sample_valid_in | input | 1 | `sample_in` is valid |
| bx1_out | output | 1 | First drive pin level |
| bx1_oe | output | 1 | Output enable of the first drive pin |
| bx2_out | output | 1 | Second drive pin level |
| demod_phase | output | 1 | Current demodulation phase |
| phase_strobe | output | 1 | One-cycle pulse on a phase flip or a settings change |
| sample_out | output | DATA_W | Demodulated sample |
| sample_valid_out | output | 1 | `sample_out` is valid |

## Verification
The assertions assume that `fsel` and `ext_mode` are clean synchronous inputs, changed only between clock edges. The bounded-counter check also assumes that any change in these settings is seen as a restart in the same cycle. The bench changes the settings only at falling edges, always to a code that differs from the current one. It holds each code for at least a full period before the next change. `bx1_in` is asynchronous by nature. To keep the latency checks exact, the bench holds it steady for more than the synchronizer depth before each check. For the same reason, demodulated samples are only checked while the phase is not moving.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    FSEL_DC   = 2'd0,
    FSEL_MID  = 2'd1,
    FSEL_SLOW = 2'd2,
    FSEL_FAST = 2'd3
  } fsel_e;

  // saturating two's complement negation
  function automatic logic [63:0] sat_neg64(input logic [63:0] v, input int unsigned w);
    logic [63:0] mask, minv, maxv;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    minv = 64'd1 << (w - 1);
    maxv = minv - 64'd1;
    if ((v & mask) == minv) return maxv;
    return (~v + 64'd1) & mask;
  endfunction
endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/exc_half_divider.sv
module exc_half_divider
  import exc_pkg::*;
#(
  parameter int BASE_LG = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] fsel,
  output logic       ph
);
  localparam int CNT_W = BASE_LG + 1;
  localparam logic [CNT_W-1:0] TERM_FAST = CNT_W'((1 << (BASE_LG - 1)) - 1);
  localparam logic [CNT_W-1:0] TERM_MID  = CNT_W'((1 << BASE_LG) - 1);
  localparam logic [CNT_W-1:0] TERM_SLOW = CNT_W'((1 << (BASE_LG + 1)) - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  always_comb begin
    case (fsel_e'(fsel))
      FSEL_FAST: term = TERM_FAST;
      FSEL_SLOW: term = TERM_SLOW;
      default:   term = TERM_MID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == term) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the half-period count never runs past the selected terminal
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !restart) |-> (cnt <= term));

  // R5: after a restart the count begins again at zero in phase 0
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !ph));
endmodule

// File: rtl/exc_demod.sv
module exc_demod
  import exc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] neg_v;

  always_comb begin
    neg_v = DATA_W'(sat_neg64(64'(din), DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= din_valid;
      if (din_valid) dout <= phase ? neg_v : din;
    end
  end

  // R8: most negative input saturates in the inverted phase
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (din_valid && phase && din == MIN_V) |=> (dout == MAX_V));

  // R7: phase 0 passes the word through
  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (din_valid && !phase) |=> (dout_valid && dout == $past(din)));
endmodule

// File: rtl/exc_bridge_drive.sv
module exc_bridge_drive
  import exc_pkg::*;
#(
  parameter int BASE_LG     = 12,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic [1:0]        fsel,
  input  logic              bx1_in,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              sample_valid_in,
  output logic              bx1_out,
  output logic              bx1_oe,
  output logic              bx2_out,
  output logic              demod_phase,
  output logic              phase_strobe,
  output logic [DATA_W-1:0] sample_out,
  output logic              sample_valid_out
);
  localparam int CFG_W = 3;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  logic             run;
  logic             div_ph;
  logic             bx1_sync;
  logic             ph_nxt;

  assign cfg_now = {ext_mode, fsel};
  assign cfg_chg = (cfg_now != cfg_q);
  assign run     = !ext_mode && (fsel_e'(fsel) != FSEL_DC);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  exc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(bx1_in), .q(bx1_sync)
  );

  exc_half_divider #(.BASE_LG(BASE_LG)) u_div (
    .clk(clk), .rst(rst), .restart(cfg_chg), .run(run), .fsel(fsel), .ph(div_ph)
  );

  always_comb begin
    if (ext_mode) ph_nxt = bx1_sync;
    else if (run) ph_nxt = div_ph;
    else          ph_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bx1_out      <= 1'b0;
      bx2_out      <= 1'b1;
      bx1_oe       <= 1'b1;
      demod_phase  <= 1'b0;
      phase_strobe <= 1'b0;
    end else begin
      bx1_out      <= ext_mode ? 1'b0 : ph_nxt;
      bx2_out      <= ~ph_nxt;
      bx1_oe       <= ~ext_mode;
      demod_phase  <= ph_nxt;
      phase_strobe <= cfg_chg || (ph_nxt != demod_phase);
    end
  end

  exc_demod #(.DATA_W(DATA_W)) u_demod (
    .clk(clk), .rst(rst), .phase(demod_phase),
    .din(sample_in), .din_valid(sample_valid_in),
    .dout(sample_out), .dout_valid(sample_valid_out)
  );

  // R1: DC code gives fixed levels
  p_dc_levels_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(ext_mode) && $past(fsel) == 2'd0) |-> (!bx1_out && bx2_out && !demod_phase));

  // R3: internal drive pair is complementary and matches the phase
  p_complement_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_mode) |-> (bx2_out == !bx1_out && demod_phase == bx1_out));

  // R4: pin released and second output mirrors the synchronized input
  p_ext_follow_r4: assert property (@(posedge clk) disable iff (rst)
    $past(ext_mode) |-> (!bx1_oe && bx2_out == !$past(bx1_sync)));

  // R6: every phase flip is flagged
  p_strobe_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (demod_phase != $past(demod_phase)) |-> phase_strobe);
endmodule

// File: tb/sim_exc_bridge_drive.sv
`timescale 1ns/1ps
module sim_exc_bridge_drive;
  localparam int BASE_LG = 4;
  localparam int DATA_W  = 12;
  localparam int SYNC    = 2;
  localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_mode = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic bx1_in = 1'b0;
  logic [DATA_W-1:0] sample_in = '0;
  logic sample_valid_in = 1'b0;
  logic bx1_out, bx1_oe, bx2_out, demod_phase, phase_strobe, sample_valid_out;
  logic [DATA_W-1:0] sample_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  exc_bridge_drive #(.BASE_LG(BASE_LG), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .fsel(fsel), .bx1_in(bx1_in),
    .sample_in(sample_in), .sample_valid_in(sample_valid_in),
    .bx1_out(bx1_out), .bx1_oe(bx1_oe), .bx2_out(bx2_out),
    .demod_phase(demod_phase), .phase_strobe(phase_strobe),
    .sample_out(sample_out), .sample_valid_out(sample_valid_out)
  );

  function automatic int half_of(input logic [1:0] code);
    case (code)
      2'd3:    return 1 << (BASE_LG - 1);
      2'd1:    return 1 << BASE_LG;
      default: return 1 << (BASE_LG + 1);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] exp_demod(input logic ph, input logic [DATA_W-1:0] v);
    if (!ph) return v;
    if (v == MINV) return MAXV;
    return -v;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic dc_check();
    check("R1", "bx1_out dc", bx1_out, 0);
    check("R1", "bx2_out dc", bx2_out, 1);
    check("R1", "phase dc", demod_phase, 0);
    check("R1", "oe dc", bx1_oe, 1);
  endtask

  // change to an AC code and time the first full period
  task automatic period_test(input logic [1:0] code);
    int h;
    h = half_of(code);
    @(negedge clk) fsel = code;
    @(posedge clk);
    @(negedge clk) check("R5", "strobe after change", phase_strobe, 1);
    repeat (h) @(posedge clk);
    @(negedge clk) check("R5", "bx1 low through first half", bx1_out, 0);
    @(posedge clk);
    @(negedge clk);
    check("R2", "bx1 rises after half", bx1_out, 1);
    check("R3", "bx2 complement", bx2_out, 0);
    check("R3", "phase equals bx1", demod_phase, 1);
    check("R6", "strobe on flip", phase_strobe, 1);
    repeat (h - 1) @(posedge clk);
    @(negedge clk) check("R2", "bx1 high second half", bx1_out, 1);
    @(posedge clk);
    @(negedge clk);
    check("R2", "bx1 falls after period", bx1_out, 0);
    check("R3", "bx2 high again", bx2_out, 1);
    check("R6", "strobe on fall", phase_strobe, 1);
    @(negedge clk) check("R6", "strobe one cycle", phase_strobe, 0);
  endtask

  task automatic demod_one(input logic ph, input logic [DATA_W-1:0] v);
    @(negedge clk) begin
      sample_in = v;
      sample_valid_in = 1'b1;
    end
    @(negedge clk) begin
      check("R7", "valid out", sample_valid_out, 1);
      if (v == MINV && ph) check("R8", "saturated", sample_out, MAXV);
      else                 check("R7", "demod data", sample_out, exp_demod(ph, v));
      sample_valid_in = 1'b0;
    end
    @(negedge clk) check("R7", "valid drops", sample_valid_out, 0);
  endtask

  task automatic set_ext_phase(input logic ph);
    @(negedge clk) bx1_in = ph;
    repeat (SYNC + 3) @(negedge clk);
    check("R4", "phase follows pin", demod_phase, ph);
    check("R4", "bx2 complement of pin", bx2_out, !ph);
    check("R4", "oe released", bx1_oe, 0);
  endtask

  initial begin
    logic [1:0] cur;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset bx1", bx1_out, 0);
    check("R9", "reset bx2", bx2_out, 1);
    check("R9", "reset oe", bx1_oe, 1);
    check("R9", "reset phase", demod_phase, 0);
    check("R9", "reset strobe", phase_strobe, 0);
    check("R9", "reset valid", sample_valid_out, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    dc_check();

    // directed codes, then random ones
    period_test(2'd1);
    period_test(2'd3);
    period_test(2'd2);
    cur = 2'd2;
    for (int i = 0; i < 12; i++) begin
      logic [1:0] nxt;
      nxt = 2'($urandom_range(0, 3));
      if (nxt == cur) nxt = nxt + 2'd1;
      if (nxt == 2'd0) begin
        @(negedge clk) fsel = 2'd0;
        repeat (3) @(negedge clk);
        dc_check();
      end else begin
        period_test(nxt);
      end
      cur = nxt;
    end

    // external phase control
    @(negedge clk) begin
      ext_mode = 1'b1;
      bx1_in = 1'b0;
    end
    @(negedge clk) check("R5", "strobe on mode change", phase_strobe, 1);
    set_ext_phase(1'b1);
    set_ext_phase(1'b0);

    // demodulator corners
    set_ext_phase(1'b1);
    demod_one(1'b1, MINV);
    demod_one(1'b1, MAXV);
    demod_one(1'b1, '0);
    set_ext_phase(1'b0);
    demod_one(1'b0, MINV);
    demod_one(1'b0, DATA_W'(5));

    for (int i = 0; i < 30; i++) begin
      logic ph;
      ph = 1'($urandom_range(0, 1));
      set_ext_phase(ph);
      demod_one(ph, DATA_W'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule